// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the raster timing for a single-scan LCD panel. A divider turns the system clock into a pixel-rate enable. On that enable, a state machine walks each line through a lead wait, the active pixels, a trail wait and a one-pixel line pulse. A line counter then closes the frame after the programmed number of lines. The output-enable, line-clock and frame-clock pins each have their own programmable active level. A bias pin inverts after every programmed number of line pulses.

At the start of every active pixel, a one-clock request strobe asks the pixel source for data. If the source has nothing ready, the previous pixel is driven again and a sticky underrun flag is set. Software clears that flag with a clear input. All configuration inputs are captured into shadow registers only when a frame begins, so reprogramming never disturbs a frame in progress.

The state machine has five states. IDLE is left on the first pixel enable after reset, going to LEAD, or to SHOW when the lead wait is zero. LEAD goes to SHOW after the lead wait. SHOW goes to TRAIL after the last active pixel, or to SYNC when the trail wait is zero. TRAIL goes to SYNC after the trail wait. SYNC lasts one pixel period and then returns to LEAD, or to SHOW when the lead wait is zero. When SYNC closes the last line, the configuration is reloaded before that choice is made.

Top module: `lcd_raster_timer`

## Requirements
- R1: One pixel period lasts N system clocks, where N is the divider input clamped to the range 2 to 512. Values below 2 act as 2 and values above 512 act as 512.
- R2: The active width is clamped to 1..800 and the active height to 1..600. A line lasts (lead + width + trail + 1) pixel periods, and a frame lasts height lines.
- R3: Each line runs in a fixed order: line pulse, then lead wait, then active pixels, then trail wait. The first active pixel therefore starts (1 + lead) pixel periods after the line pulse starts. A wait of zero is skipped.
- R4: Output enable is at its active level for exactly width pixel periods per line, only during active pixels, and never together with the line pulse.
- R5: The line clock is active for exactly one pixel period per line, after the trail wait. The frame clock is active only during the line pulse that ends the first line of every frame.
- R6: Each of the three polarity inputs selects the active level of its own pin: 1 means active high and 0 means active low.
- R7: The bias pin inverts once every B line pulses, where B is the bias-period input. B = 0 keeps the bias pin constant.
- R8: The pixel request is a one-clock strobe on the clock edge that begins each active pixel. The data accepted with that request appears on the data output from that edge until the next request.
- R9: A request taken while the source is not valid repeats the previous data output and sets the underrun flag. The flag stays set until the clear input is high in a cycle with no new underrun. When an underrun and a clear fall in the same cycle, the set wins.
- R10: All configuration inputs are sampled only when a frame begins. A change made mid-frame takes effect from the next frame.
- R11: While reset is asserted and just after it, the control pins are low (the polarity shadows reset to active high), the bias pin is low, the data output is zero, the underrun flag is clear and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_div | input | 10 | Pixel clock divisor (clamped 2..512) |
| cfg_h_active | input | 10 | Active pixels per line (clamped 1..800) |
| cfg_v_active | input | 10 | Lines per frame (clamped 1..600) |
| cfg_lead_wait | input | 8 | Pixel periods of wait before active data |
| cfg_trail_wait | input | 8 | Pixel periods of wait after active data |
| cfg_bias_lines | input | 8 | Line pulses between bias inversions, 0 = hold |
| cfg_oe_pol | input | 1 | Output-enable active level |
| cfg_lclk_pol | input | 1 | Line-clock active level |
| cfg_fclk_pol | input | 1 | Frame-clock active level |
| pix_req | output | 1 | Strobe asking for the next pixel |
| pix_valid | input | 1 | Source has a pixel on pix_data |
| pix_data | input | 24 | Pixel value from the source |
| underrun_clr | input | 1 | Clears the underrun flag |
| pnl_data | output | 24 | Pixel value driven to the panel |
| pnl_oe | output | 1 | Output enable |
| pnl_lclk | output | 1 | Line clock |
| pnl_fclk | output | 1 | Frame clock |
| pnl_bias | output | 1 | AC bias |
| underrun_irq | output | 1 | Sticky underrun flag |

## Verification
The underrun flag can be set by a missing pixel and cleared by software in the same clock cycle. The bench provokes this by holding the clear input high and the valid input low across a pixel request. It then expects the flag to read set just after that request edge, and cleared one clock later once no new request has arrived. The other coincidence is the frame clock, which shares its pixel period with the line pulse. The bench checks this by detecting frame starts through the frame clock while timing lines through the line clock.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHOW,
        ST_TRAIL,
        ST_SYNC
    } raster_st_t;

endpackage

// File: rtl/lcd_pix_divider.sv
module lcd_pix_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // div_val is at least 2; a shrinking divisor is caught by the >= compare
    assign tick = (cnt >= div_val - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/lcd_bias_toggle.sv
module lcd_bias_toggle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [CNT_W-1:0] period,
    output logic             bias
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bias <= 1'b0;
        end else if (line_end) begin
            if (period == '0) begin
                cnt <= '0;
            end else if (cnt >= period - CNT_W'(1)) begin
                cnt  <= '0;
                bias <= ~bias;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_raster_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 512,
    parameter int H_W     = 10,
    parameter int H_MAX   = 800,
    parameter int V_W     = 10,
    parameter int V_MAX   = 600,
    parameter int WAIT_W  = 8,
    parameter int BIAS_W  = 8,
    parameter int PIX_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_clk_div,
    input  logic [H_W-1:0]    cfg_h_active,
    input  logic [V_W-1:0]    cfg_v_active,
    input  logic [WAIT_W-1:0] cfg_lead_wait,
    input  logic [WAIT_W-1:0] cfg_trail_wait,
    input  logic [BIAS_W-1:0] cfg_bias_lines,
    input  logic              cfg_oe_pol,
    input  logic              cfg_lclk_pol,
    input  logic              cfg_fclk_pol,
    output logic              pix_req,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              underrun_clr,
    output logic [PIX_W-1:0]  pnl_data,
    output logic              pnl_oe,
    output logic              pnl_lclk,
    output logic              pnl_fclk,
    output logic              pnl_bias,
    output logic              underrun_irq
);
    localparam int CW = (H_W > WAIT_W) ? H_W : WAIT_W;

    raster_st_t state, nxt;

    // frame shadows
    logic [DIV_W-1:0]  div_sh;
    logic [H_W-1:0]    h_sh;
    logic [V_W-1:0]    v_sh;
    logic [WAIT_W-1:0] lead_sh, trail_sh;
    logic [BIAS_W-1:0] bias_sh;
    logic              oe_pol_sh, lclk_pol_sh, fclk_pol_sh;

    logic [DIV_W-1:0]  div_in;
    logic [H_W-1:0]    h_in;
    logic [V_W-1:0]    v_in;

    logic [CW-1:0]     pix_cnt;
    logic [V_W-1:0]    line_cnt;
    logic              px_tick;
    logic              last_line;
    logic              frame_load;
    logic              oe_on, lp_on, fp_on;

    // clamp the incoming configuration to the supported range
    always_comb begin
        if (cfg_clk_div < DIV_W'(DIV_MIN))      div_in = DIV_W'(DIV_MIN);
        else if (cfg_clk_div > DIV_W'(DIV_MAX)) div_in = DIV_W'(DIV_MAX);
        else                                    div_in = cfg_clk_div;
        if (cfg_h_active == '0)                 h_in = H_W'(1);
        else if (cfg_h_active > H_W'(H_MAX))    h_in = H_W'(H_MAX);
        else                                    h_in = cfg_h_active;
        if (cfg_v_active == '0)                 v_in = V_W'(1);
        else if (cfg_v_active > V_W'(V_MAX))    v_in = V_W'(V_MAX);
        else                                    v_in = cfg_v_active;
    end

    lcd_pix_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_sh),
        .tick    (px_tick)
    );

    lcd_bias_toggle #(.CNT_W(BIAS_W)) u_bias (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (px_tick && (state == ST_SYNC)),
        .period   (bias_sh),
        .bias     (pnl_bias)
    );

    assign last_line  = (line_cnt == v_sh - V_W'(1));
    assign frame_load = px_tick && ((state == ST_IDLE) ||
                                    ((state == ST_SYNC) && last_line));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (px_tick)
                    nxt = (cfg_lead_wait == '0) ? ST_SHOW : ST_LEAD;
            end
            ST_LEAD: begin
                if (px_tick && (pix_cnt == CW'(lead_sh) - CW'(1)))
                    nxt = ST_SHOW;
            end
            ST_SHOW: begin
                if (px_tick && (pix_cnt == CW'(h_sh) - CW'(1)))
                    nxt = (trail_sh == '0) ? ST_SYNC : ST_TRAIL;
            end
            ST_TRAIL: begin
                if (px_tick && (pix_cnt == CW'(trail_sh) - CW'(1)))
                    nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (px_tick) begin
                    if (last_line)
                        nxt = (cfg_lead_wait == '0) ? ST_SHOW : ST_LEAD;
                    else
                        nxt = (lead_sh == '0) ? ST_SHOW : ST_LEAD;
                end
            end
        endcase
    end

    assign pix_req = px_tick && (nxt == ST_SHOW);

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pix_cnt  <= '0;
            line_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                pix_cnt <= '0;
            else if (px_tick)
                pix_cnt <= pix_cnt + CW'(1);
            if (px_tick && (state == ST_SYNC))
                line_cnt <= last_line ? '0 : line_cnt + V_W'(1);
        end
    end

    // configuration shadows, loaded only at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sh      <= DIV_W'(DIV_MIN);
            h_sh        <= H_W'(1);
            v_sh        <= V_W'(1);
            lead_sh     <= '0;
            trail_sh    <= '0;
            bias_sh     <= '0;
            oe_pol_sh   <= 1'b1;
            lclk_pol_sh <= 1'b1;
            fclk_pol_sh <= 1'b1;
        end else if (frame_load) begin
            div_sh      <= div_in;
            h_sh        <= h_in;
            v_sh        <= v_in;
            lead_sh     <= cfg_lead_wait;
            trail_sh    <= cfg_trail_wait;
            bias_sh     <= cfg_bias_lines;
            oe_pol_sh   <= cfg_oe_pol;
            lclk_pol_sh <= cfg_lclk_pol;
            fclk_pol_sh <= cfg_fclk_pol;
        end
    end

    // pixel data path and sticky underrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pnl_data     <= '0;
            underrun_irq <= 1'b0;
        end else begin
            if (pix_req && pix_valid)
                pnl_data <= pix_data;
            if (pix_req && !pix_valid)
                underrun_irq <= 1'b1;
            else if (underrun_clr)
                underrun_irq <= 1'b0;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        oe_on    = (state == ST_SHOW);
        lp_on    = (state == ST_SYNC);
        fp_on    = (state == ST_SYNC) && (line_cnt == '0);
        pnl_oe   = oe_pol_sh   ? oe_on : ~oe_on;
        pnl_lclk = lclk_pol_sh ? lp_on : ~lp_on;
        pnl_fclk = fclk_pol_sh ? fp_on : ~fp_on;
    end
endmodule

// File: rtl/lcd_raster_checks.sv
module lcd_raster_checks #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pix_req,
    input logic             pix_valid,
    input logic             underrun_clr,
    input logic             irq,
    input logic [PIX_W-1:0] pnl_data,
    input logic             oe_on,
    input logic             lp_on,
    input logic             fp_on
);
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_oe_not_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_on |-> !lp_on);

    p_fp_inside_lp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fp_on |-> lp_on);

    p_req_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> tick);

    p_underrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_valid) |=> irq);

    p_underrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !underrun_clr) |=> irq);

    p_underrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_clr && !(pix_req && !pix_valid)) |=> !irq);

    p_underrun_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !pix_valid) |=> $stable(pnl_data));
endmodule

bind lcd_raster_timer lcd_raster_checks #(.PIX_W(PIX_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (px_tick),
    .pix_req      (pix_req),
    .pix_valid    (pix_valid),
    .underrun_clr (underrun_clr),
    .irq          (underrun_irq),
    .pnl_data     (pnl_data),
    .oe_on        (oe_on),
    .lp_on        (lp_on),
    .fp_on        (fp_on)
);

// File: tb/lcd_raster_timer_test.sv
module lcd_raster_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_clk_div = 10'd2;
    logic [9:0]  cfg_h_active = 10'd4;
    logic [9:0]  cfg_v_active = 10'd3;
    logic [7:0]  cfg_lead_wait = 8'd1;
    logic [7:0]  cfg_trail_wait = 8'd2;
    logic [7:0]  cfg_bias_lines = 8'd0;
    logic        cfg_oe_pol = 1'b1;
    logic        cfg_lclk_pol = 1'b1;
    logic        cfg_fclk_pol = 1'b1;
    logic        pix_req;
    logic        pix_valid = 1'b1;
    logic [23:0] pix_data = 24'h000100;
    logic        underrun_clr = 1'b0;
    logic [23:0] pnl_data;
    logic        pnl_oe, pnl_lclk, pnl_fclk, pnl_bias, underrun_irq;

    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    lcd_raster_timer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_clk_div(cfg_clk_div), .cfg_h_active(cfg_h_active),
        .cfg_v_active(cfg_v_active), .cfg_lead_wait(cfg_lead_wait),
        .cfg_trail_wait(cfg_trail_wait), .cfg_bias_lines(cfg_bias_lines),
        .cfg_oe_pol(cfg_oe_pol), .cfg_lclk_pol(cfg_lclk_pol),
        .cfg_fclk_pol(cfg_fclk_pol), .pix_req(pix_req),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .underrun_clr(underrun_clr), .pnl_data(pnl_data),
        .pnl_oe(pnl_oe), .pnl_lclk(pnl_lclk), .pnl_fclk(pnl_fclk),
        .pnl_bias(pnl_bias), .underrun_irq(underrun_irq)
    );

    // divisor, width, height, lead, trail
    localparam int NVEC = 8;
    localparam int VEC [NVEC][5] = '{
        '{2,    4,    3,    1, 2},
        '{3,    5,    2,    0, 0},
        '{2,    1,    1,    0, 0},
        '{1,    3,    2,    2, 1},
        '{5,    2,    4,    3, 0},
        '{1000, 1,    1,    0, 0},
        '{4,    1023, 1,    0, 0},
        '{2,    1,    1023, 0, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic bit oe_act();   return pnl_oe   == cfg_oe_pol;   endfunction
    function automatic bit lp_act();   return pnl_lclk == cfg_lclk_pol; endfunction
    function automatic bit fp_act();   return pnl_fclk == cfg_fclk_pol; endfunction

    task automatic wait_fp_rise();
        bit p = fp_act();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (fp_act() && !p) return;
            p = fp_act();
        end
    endtask

    task automatic wait_lp_rise(output int n);
        bit p = lp_act();
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            n++;
            if (lp_act() && !p) return;
            p = lp_act();
        end
    endtask

    // starts at a frame-clock rise; times one line and one frame
    task automatic measure(input int d, output int L, output int F, output int oec,
                           output int first_oe, output int lpw, output logic [2:0] pins);
        bit pl = 1'b1, pf = 1'b1;
        int n = 0;
        wait_fp_rise();
        L = -1; F = -1; oec = 0; first_oe = -1; lpw = 0; pins = 3'b000;
        while (n < 20000) begin
            if (n > 0 && L < 0 && lp_act() && !pl) L = n;
            if (n > 0 && fp_act() && !pf) begin F = n; break; end
            if (L < 0) begin
                if (lp_act()) lpw++;
                if (oe_act()) begin
                    oec++;
                    if (first_oe < 0) first_oe = n;
                end
            end
            if (n == d) pins = {pnl_oe, pnl_lclk, pnl_fclk};
            pl = lp_act();
            pf = fp_act();
            @(negedge clk);
            n++;
        end
    endtask

    // data monitor: each request is checked on the following negedge (R8, R9)
    initial begin
        logic [23:0] exp_d = '0;
        bit have = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (have) begin
                    check(pnl_data == exp_d, "R8/R9 data", int'(pnl_data), int'(exp_d));
                    pix_data = pix_data + 24'h000101;
                end
                have = 1'b0;
                if (pix_req) begin
                    if (pix_valid) exp_d = pix_data;
                    have = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int L, F, oec, fo, lpw, d, h, v, p, q, n, tog;
        logic [2:0] pins;
        bit pb;

        // R11 reset state
        repeat (3) @(negedge clk);
        check({pnl_oe, pnl_lclk, pnl_fclk} == 3'b000, "R11 ctrl pins", int'({pnl_oe, pnl_lclk, pnl_fclk}), 0);
        check(pnl_bias == 1'b0 && underrun_irq == 1'b0, "R11 bias/irq", int'({pnl_bias, underrun_irq}), 0);
        check(pnl_data == '0 && pix_req == 1'b0, "R11 data/req", int'(pnl_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pnl_oe, pnl_lclk, pnl_fclk, underrun_irq} == 4'b0000, "R11 after release",
              int'({pnl_oe, pnl_lclk, pnl_fclk, underrun_irq}), 0);
        mon_on = 1'b1;

        // vector walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            cfg_clk_div    = 10'(VEC[i][0]);
            cfg_h_active   = 10'(VEC[i][1]);
            cfg_v_active   = 10'(VEC[i][2]);
            cfg_lead_wait  = 8'(VEC[i][3]);
            cfg_trail_wait = 8'(VEC[i][4]);
            d = clampi(VEC[i][0], 2, 512);
            h = clampi(VEC[i][1], 1, 800);
            v = clampi(VEC[i][2], 1, 600);
            p = VEC[i][3];
            q = VEC[i][4];
            wait_fp_rise();
            measure(d, L, F, oec, fo, lpw, pins);
            check(L == d * (p + h + q + 1), "R1/R2 line length", L, d * (p + h + q + 1));
            check(F == v * d * (p + h + q + 1), "R2 frame length", F, v * d * (p + h + q + 1));
            check(oec == d * h, "R4 enable per line", oec, d * h);
            check(lpw == d, "R5 line pulse width", lpw, d);
            check(fo == d * (1 + p), "R3 lead before active", fo, d * (1 + p));
        end

        // R6 polarity: enable and line clock active low, frame clock high
        cfg_clk_div = 10'd2; cfg_h_active = 10'd4; cfg_v_active = 10'd3;
        cfg_lead_wait = 8'd1; cfg_trail_wait = 8'd2;
        cfg_oe_pol = 1'b0; cfg_lclk_pol = 1'b0;
        wait_fp_rise();
        wait_fp_rise();
        measure(2, L, F, oec, fo, lpw, pins);
        check(L == 16 && oec == 8, "R6 active-low timing", L * 100 + oec, 1608);
        check(pins == 3'b110, "R6 idle levels in lead wait", int'(pins), 6);
        cfg_oe_pol = 1'b1; cfg_lclk_pol = 1'b1;

        // R7 bias every 3 lines, then held
        cfg_bias_lines = 8'd3;
        wait_fp_rise();
        wait_fp_rise();
        wait_lp_rise(n);
        tog = 0; pb = pnl_bias;
        for (int k = 0; k < 192; k++) begin
            @(negedge clk);
            if (pnl_bias != pb) tog++;
            pb = pnl_bias;
        end
        check(tog == 4, "R7 bias toggles per 12 lines", tog, 4);
        cfg_bias_lines = 8'd0;
        wait_fp_rise();
        wait_fp_rise();
        tog = 0; pb = pnl_bias;
        for (int k = 0; k < 192; k++) begin
            @(negedge clk);
            if (pnl_bias != pb) tog++;
            pb = pnl_bias;
        end
        check(tog == 0, "R7 bias held at zero period", tog, 0);

        // R10 mid-frame change ignored until next frame
        wait_fp_rise();
        cfg_h_active = 10'd6;
        wait_lp_rise(n);
        check(n == 16, "R10 line keeps old width", n, 16);
        measure(2, L, F, oec, fo, lpw, pins);
        check(L == 20 && oec == 12, "R10 new width next frame", L * 100 + oec, 2012);
        cfg_h_active = 10'd4;
        wait_fp_rise();

        // R9 underrun: repeat, sticky, clear, set wins over clear
        pix_valid = 1'b0;
        do @(negedge clk); while (!pix_req);
        @(negedge clk);
        check(underrun_irq == 1'b1, "R9 flag set on underrun", int'(underrun_irq), 1);
        pix_valid = 1'b1;
        repeat (5) @(negedge clk);
        check(underrun_irq == 1'b1, "R9 flag sticky", int'(underrun_irq), 1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        check(underrun_irq == 1'b0, "R9 flag cleared", int'(underrun_irq), 0);
        do @(negedge clk); while (pix_req);
        pix_valid = 1'b0;
        underrun_clr = 1'b1;
        do @(negedge clk); while (!pix_req);
        @(negedge clk);
        check(underrun_irq == 1'b1, "R9 set wins over clear", int'(underrun_irq), 1);
        pix_valid = 1'b1;
        @(negedge clk);
        check(underrun_irq == 1'b0, "R9 clear after collision", int'(underrun_irq), 0);
        underrun_clr = 1'b0;
        repeat (40) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule